// File: doc/BRIEF.md
# Parallel LCD Bus Timing Engine

This block is the bus master for an 8080-style parallel link to an external display controller. Every bus cycle is scheduled on a tick counter. The chip-select, write-strobe and read-strobe pins each have their own programmed assert and release tick. A separate sample tick captures read data. Per-kind cycle lengths set when the cycle ends. A tick is one clock, or two clocks when the divider bit is set.

A client issues a command write, a data/parameter write or a single read by pulsing one of three request inputs while the engine is idle. The engine raises `busy` for the length of the cycle and drives the panel pins. It then pulses `done` for one clock. A read returns the sampled bus value on `rd_data`. The bus is 8 or 16 bits wide. The data pad is split into output, output-enable and input signals, for connection to a bidirectional pad.

Timing inputs are assumed legal: each strobe releases after it asserts, CS releases no earlier than either strobe, each cycle length is at least its strobe release tick, and the sample tick is later than the read-strobe assert tick. Inputs are held stable while a cycle is running.

Top module: `lcd_bus_engine`

## Requirements
- R1: During and after reset, before any request: `lcd_cs_n`, `lcd_we_n` and `lcd_re_n` are 1, `lcd_dc` is 1, `busy`, `done` and `lcd_db_oe` are 0, and `rd_data` is 0.
- R2: The tick counter is 0 on the clock after a request is accepted. It advances by one every clock when `div_sel`=0, and every second clock when `div_sel`=1.
- R3: While a cycle runs, `lcd_cs_n` is low exactly while the counter value c satisfies `cs_on` <= c < `cs_off`.
- R4: `lcd_we_n` is low while `we_on` <= c < `we_off`, in command and data cycles only. `lcd_re_n` is low while `re_on` <= c < `re_off`, in read cycles only. Otherwise both are high.
- R5: A cycle ends when the counter would reach E. E is the larger of `cs_min` and the kind's cycle length (`wr_cycle` for writes, `rd_cycle` for reads). `busy` then stays high for exactly E ticks, and `done` is high for the one clock in which `busy` has just fallen.
- R6: Requests are taken only while `busy` is 0 and are otherwise ignored. When several are raised together, command wins over data, and data wins over read.
- R7: `lcd_dc` is 0 for a command cycle and 1 for data and read cycles. It is set on acceptance, is held for the whole cycle, and keeps its value until the next acceptance.
- R8: `lcd_db_oe` is 1 for the whole of a command or data cycle and 0 otherwise. While it is 1, `lcd_db_out` carries `wr_data` as it was on acceptance. With `wide_sel`=0 (8-bit bus) the upper byte is 0.
- R9: In a read cycle, `lcd_db_in` is captured into `rd_data` at the clock edge where the counter reaches `acc_time`. No capture happens if `acc_time` exceeds E. `rd_data` holds between captures. With `wide_sel`=0 the upper byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 1 | 0: tick = 1 clock, 1: tick = 2 clocks |
| wide_sel | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| cs_on | input | 4 | CS assert tick |
| cs_off | input | 6 | CS release tick |
| we_on | input | 4 | Write strobe assert tick |
| we_off | input | 6 | Write strobe release tick |
| re_on | input | 4 | Read strobe assert tick |
| re_off | input | 6 | Read strobe release tick |
| wr_cycle | input | 6 | Write cycle length in ticks |
| rd_cycle | input | 6 | Read cycle length in ticks |
| cs_min | input | 6 | Minimum cycle length in ticks |
| acc_time | input | 6 | Read sample tick |
| cmd_req | input | 1 | Start a command write |
| dat_req | input | 1 | Start a data/parameter write |
| rd_req | input | 1 | Start a single read |
| wr_data | input | 16 | Write value |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 16 | Last captured read value |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_we_n | output | 1 | Write strobe, active low |
| lcd_re_n | output | 1 | Read strobe, active low |
| lcd_dc | output | 1 | 0 command, 1 data |
| lcd_db_out | output | 16 | Data pad output value |
| lcd_db_oe | output | 1 | Data pad output enable |
| lcd_db_in | input | 16 | Data pad input value |

## Verification
The embedded assertions check, on every clock, these properties:
- `done` never lasts two clocks, and every fall of `busy` comes with it.
- The counter stays below the cycle end.
- D/C and the accepted cycle kind do not move mid-cycle.
- The two strobes are never low together.
- The divided tick never fires on adjacent clocks.
- The driven word and the captured word only change when they should.

Only the bench scenarios can show that each strobe edge lands on the programmed tick. The same holds for E taking the larger of the cycle length and the minimum width, for the request priority, for the 8-bit masking and for a late sample tick skipping capture. The bench shows these by comparing every pin against a clock-count model.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

    typedef enum logic [1:0] {
        OP_CMD = 2'd0,
        OP_DAT = 2'd1,
        OP_RD  = 2'd2
    } op_e;

    // fixed priority: command, then data, then read
    function automatic op_e pick_op(input logic c, input logic d);
        if (c)      return OP_CMD;
        else if (d) return OP_DAT;
        else        return OP_RD;
    endfunction

endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic div2,
    output logic tick
);
    typedef struct packed {
        logic phase;
    } tg_s;

    tg_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart || !div2) begin
            s_d.phase = 1'b0;
        end else if (run) begin
            s_d.phase = ~s_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = run && (!div2 || s_q.phase);

    // R2
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div2 && tick) |=> !tick);

endmodule

// File: rtl/lcd_cycle_seq.sv
module lcd_cycle_seq
    import lcd_bus_pkg::*;
#(
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_req,
    input  logic             dat_req,
    input  logic             rd_req,
    input  logic [OFF_W-1:0] wr_cycle,
    input  logic [OFF_W-1:0] rd_cycle,
    input  logic [OFF_W-1:0] cs_min,
    input  logic [OFF_W-1:0] acc_time,
    output logic             accept,
    output logic             cap_en,
    output logic             busy_q,
    output logic             done_q,
    output logic             dc_q,
    output logic             nxt_busy,
    output op_e              nxt_op,
    output logic [OFF_W-1:0] nxt_cnt
);
    localparam int CW = OFF_W + 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             dc;
        op_e              op;
        logic [OFF_W-1:0] cnt;
    } seq_s;

    seq_s s_d, s_q;

    logic [OFF_W-1:0] kind_len;
    logic [OFF_W-1:0] end_cnt;
    logic [CW-1:0]    cnt_inc;

    always_comb begin
        kind_len = (s_q.op == OP_RD) ? rd_cycle : wr_cycle;
        end_cnt  = (cs_min > kind_len) ? cs_min : kind_len;
        cnt_inc  = {1'b0, s_q.cnt} + CW'(1);
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = 1'b0;
        cap_en   = 1'b0;
        if (s_q.busy) begin
            if (tick) begin
                if (s_q.op == OP_RD && cnt_inc == {1'b0, acc_time}) begin
                    cap_en = 1'b1;
                end
                if (cnt_inc == {1'b0, end_cnt}) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = cnt_inc[OFF_W-1:0];
                end
            end
        end else if (cmd_req || dat_req || rd_req) begin
            accept   = 1'b1;
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.op   = pick_op(cmd_req, dat_req);
            s_d.dc   = !cmd_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.dc   <= 1'b1;
            s_q.op   <= OP_CMD;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_q   = s_q.busy;
    assign done_q   = s_q.done;
    assign dc_q     = s_q.dc;
    assign nxt_busy = s_d.busy;
    assign nxt_op   = s_d.op;
    assign nxt_cnt  = s_d.cnt;

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R5
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (s_q.cnt < end_cnt));
    // R7
    dc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(dc_q));
    // R6
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(s_q.op));

endmodule

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen
    import lcd_bus_pkg::*;
#(
    parameter int ON_W  = 4,
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nxt_busy,
    input  op_e              nxt_op,
    input  logic [OFF_W-1:0] nxt_cnt,
    input  logic [ON_W-1:0]  cs_on,
    input  logic [OFF_W-1:0] cs_off,
    input  logic [ON_W-1:0]  we_on,
    input  logic [OFF_W-1:0] we_off,
    input  logic [ON_W-1:0]  re_on,
    input  logic [OFF_W-1:0] re_off,
    output logic             cs_n,
    output logic             we_n,
    output logic             re_n
);
    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic re_n;
    } stb_s;

    stb_s s_d, s_q;

    function automatic logic in_win(input logic [OFF_W-1:0] c,
                                    input logic [ON_W-1:0]  on_t,
                                    input logic [OFF_W-1:0] off_t);
        return (OFF_W'(on_t) <= c) && (c < off_t);
    endfunction

    always_comb begin
        s_d.cs_n = !(nxt_busy && in_win(nxt_cnt, cs_on, cs_off));
        s_d.we_n = !(nxt_busy && nxt_op != OP_RD && in_win(nxt_cnt, we_on, we_off));
        s_d.re_n = !(nxt_busy && nxt_op == OP_RD && in_win(nxt_cnt, re_on, re_off));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign cs_n = s_q.cs_n;
    assign we_n = s_q.we_n;
    assign re_n = s_q.re_n;

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

endmodule

// File: rtl/lcd_data_path.sv
module lcd_data_path
    import lcd_bus_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             cap_en,
    input  logic             wide,
    input  logic             nxt_busy,
    input  op_e              nxt_op,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [BUS_W-1:0] db_in,
    output logic [BUS_W-1:0] db_out,
    output logic             db_oe,
    output logic [BUS_W-1:0] rd_data
);
    localparam int LANES = BUS_W / 8;

    typedef struct packed {
        logic             oe;
        logic [BUS_W-1:0] dout;
        logic [BUS_W-1:0] rd;
    } dp_s;

    dp_s s_d, s_q;
    logic [BUS_W-1:0] lane_mask;

    // byte lane 0 always carries data; higher lanes only on the wide bus
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_base
            assign lane_mask[7:0] = 8'hFF;
        end else begin : g_upper
            assign lane_mask[k*8 +: 8] = {8{wide}};
        end
    end

    always_comb begin
        s_d    = s_q;
        s_d.oe = nxt_busy && (nxt_op != OP_RD);
        if (accept) s_d.dout = wr_data & lane_mask;
        if (cap_en) s_d.rd   = db_in & lane_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign db_oe   = s_q.oe;
    assign db_out  = s_q.dout;
    assign rd_data = s_q.rd;

    // R8
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe && $past(db_oe)) |-> $stable(db_out));
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> $stable(rd_data));

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
    import lcd_bus_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int ON_W  = 4,
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_sel,
    input  logic             wide_sel,
    input  logic [ON_W-1:0]  cs_on,
    input  logic [OFF_W-1:0] cs_off,
    input  logic [ON_W-1:0]  we_on,
    input  logic [OFF_W-1:0] we_off,
    input  logic [ON_W-1:0]  re_on,
    input  logic [OFF_W-1:0] re_off,
    input  logic [OFF_W-1:0] wr_cycle,
    input  logic [OFF_W-1:0] rd_cycle,
    input  logic [OFF_W-1:0] cs_min,
    input  logic [OFF_W-1:0] acc_time,
    input  logic             cmd_req,
    input  logic             dat_req,
    input  logic             rd_req,
    input  logic [BUS_W-1:0] wr_data,
    output logic             busy,
    output logic             done,
    output logic [BUS_W-1:0] rd_data,
    output logic             lcd_cs_n,
    output logic             lcd_we_n,
    output logic             lcd_re_n,
    output logic             lcd_dc,
    output logic [BUS_W-1:0] lcd_db_out,
    output logic             lcd_db_oe,
    input  logic [BUS_W-1:0] lcd_db_in
);
    logic             tick;
    logic             accept;
    logic             cap_en;
    logic             nxt_busy;
    op_e              nxt_op;
    logic [OFF_W-1:0] nxt_cnt;

    lcd_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (accept),
        .div2    (div_sel),
        .tick    (tick)
    );

    lcd_cycle_seq #(.OFF_W(OFF_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmd_req  (cmd_req),
        .dat_req  (dat_req),
        .rd_req   (rd_req),
        .wr_cycle (wr_cycle),
        .rd_cycle (rd_cycle),
        .cs_min   (cs_min),
        .acc_time (acc_time),
        .accept   (accept),
        .cap_en   (cap_en),
        .busy_q   (busy),
        .done_q   (done),
        .dc_q     (lcd_dc),
        .nxt_busy (nxt_busy),
        .nxt_op   (nxt_op),
        .nxt_cnt  (nxt_cnt)
    );

    lcd_strobe_gen #(.ON_W(ON_W), .OFF_W(OFF_W)) u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_busy (nxt_busy),
        .nxt_op   (nxt_op),
        .nxt_cnt  (nxt_cnt),
        .cs_on    (cs_on),
        .cs_off   (cs_off),
        .we_on    (we_on),
        .we_off   (we_off),
        .re_on    (re_on),
        .re_off   (re_off),
        .cs_n     (lcd_cs_n),
        .we_n     (lcd_we_n),
        .re_n     (lcd_re_n)
    );

    lcd_data_path #(.BUS_W(BUS_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cap_en   (cap_en),
        .wide     (wide_sel),
        .nxt_busy (nxt_busy),
        .nxt_op   (nxt_op),
        .wr_data  (wr_data),
        .db_in    (lcd_db_in),
        .db_out   (lcd_db_out),
        .db_oe    (lcd_db_oe),
        .rd_data  (rd_data)
    );

    // R8
    drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> (busy && lcd_re_n));

endmodule

// File: tb/lcd_bus_engine_tb.sv
module lcd_bus_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_sel = 1'b0, wide_sel = 1'b1;
    logic [3:0]  cs_on, we_on, re_on;
    logic [5:0]  cs_off, we_off, re_off, wr_cycle, rd_cycle, cs_min, acc_time;
    logic        cmd_req = 1'b0, dat_req = 1'b0, rd_req = 1'b0;
    logic [15:0] wr_data = '0, db_in = '0;
    logic        busy, done, lcd_cs_n, lcd_we_n, lcd_re_n, lcd_dc, lcd_db_oe;
    logic [15:0] rd_data, lcd_db_out;

    int total = 0, bad = 0, cyc = 0;
    bit chk_on = 0;

    always #4 clk = ~clk;

    lcd_bus_engine u_dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .wide_sel(wide_sel),
        .cs_on(cs_on), .cs_off(cs_off), .we_on(we_on), .we_off(we_off),
        .re_on(re_on), .re_off(re_off), .wr_cycle(wr_cycle), .rd_cycle(rd_cycle),
        .cs_min(cs_min), .acc_time(acc_time), .cmd_req(cmd_req), .dat_req(dat_req),
        .rd_req(rd_req), .wr_data(wr_data), .busy(busy), .done(done),
        .rd_data(rd_data), .lcd_cs_n(lcd_cs_n), .lcd_we_n(lcd_we_n),
        .lcd_re_n(lcd_re_n), .lcd_dc(lcd_dc), .lcd_db_out(lcd_db_out),
        .lcd_db_oe(lcd_db_oe), .lcd_db_in(db_in)
    );

    // behavioural model: clocks elapsed since acceptance
    int          m_active, m_n, m_div, m_end, m_kind;
    logic        m_dc, m_done;
    logic [15:0] m_data, m_rd;

    function automatic logic [15:0] bmask();
        return wide_sel ? 16'hFFFF : 16'h00FF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_n = 0; m_div = 1; m_end = 1; m_kind = 0;
            m_dc = 1'b1; m_done = 1'b0; m_data = '0; m_rd = '0;
        end else begin
            int was;
            was = m_active;
            m_done = 1'b0;
            if (was != 0) begin
                m_n++;
                if (m_kind == 2 && int'(acc_time) <= m_end && m_n == int'(acc_time) * m_div)
                    m_rd = db_in & bmask();
                if (m_n == m_end * m_div) begin
                    m_active = 0; m_done = 1'b1;
                end
            end else if (cmd_req || dat_req || rd_req) begin
                int len;
                m_kind = cmd_req ? 0 : (dat_req ? 1 : 2);
                m_active = 1; m_n = 0;
                m_div = div_sel ? 2 : 1;
                len = (m_kind == 2) ? int'(rd_cycle) : int'(wr_cycle);
                m_end = (int'(cs_min) > len) ? int'(cs_min) : len;
                m_dc = (m_kind != 0);
                m_data = wr_data & bmask();
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            int c;
            logic wr, rd;
            c  = m_n / m_div;
            wr = (m_active != 0) && m_kind != 2;
            rd = (m_active != 0) && m_kind == 2;
            chk("R2 R3 cs_n", 16'(lcd_cs_n),
                16'(!((m_active != 0) && c >= int'(cs_on) && c < int'(cs_off))));
            chk("R4 we_n", 16'(lcd_we_n), 16'(!(wr && c >= int'(we_on) && c < int'(we_off))));
            chk("R4 re_n", 16'(lcd_re_n), 16'(!(rd && c >= int'(re_on) && c < int'(re_off))));
            chk("R5 busy", 16'(busy), 16'(m_active != 0));
            chk("R5 done", 16'(done), 16'(m_done));
            chk("R7 dc", 16'(lcd_dc), 16'(m_dc));
            chk("R8 oe", 16'(lcd_db_oe), 16'(wr));
            if (wr) chk("R8 db_out", lcd_db_out, m_data);
            chk("R9 rd_data", rd_data, m_rd);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic set_t(input int a, b, c, d, e, f, g, h, i, j);
        cs_on = 4'(a); cs_off = 6'(b); we_on = 4'(c); we_off = 6'(d);
        re_on = 4'(e); re_off = 6'(f); wr_cycle = 6'(g); rd_cycle = 6'(h);
        cs_min = 6'(i); acc_time = 6'(j);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic issue(input bit c, input bit d, input bit r, input logic [15:0] v);
        wait_idle();
        @(negedge clk);
        cmd_req = c; dat_req = d; rd_req = r; wr_data = v;
        @(negedge clk);
        cmd_req = 0; dat_req = 0; rd_req = 0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        set_t(1, 8, 2, 6, 2, 7, 9, 10, 3, 5);
        repeat (3) @(negedge clk);
        chk_on = 1;
        // R1 reset values while held in reset
        chk("R1 cs_n", 16'(lcd_cs_n), 16'd1);
        chk("R1 dc", 16'(lcd_dc), 16'd1);
        chk("R1 busy", 16'(busy), 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 oe", 16'(lcd_db_oe), 16'd0);

        // 16-bit, one clock per tick
        issue(1, 0, 0, 16'hA55A);
        measure(n);
        chk("R5 write length", 16'(n), 16'd9);
        issue(0, 1, 0, 16'h3C96);
        db_in = 16'h1234;
        issue(0, 0, 1, 16'h0);
        measure(n);
        chk("R5 read length", 16'(n), 16'd10);
        chk("R9 captured", rd_data, 16'h1234);

        // two clocks per tick
        div_sel = 1'b1;
        issue(0, 1, 0, 16'h0F0F);
        measure(n);
        chk("R2 divided length", 16'(n), 16'd18);
        db_in = 16'h5AA5;
        issue(0, 0, 1, 16'h0);
        wait_idle();
        chk("R9 divided capture", rd_data, 16'h5AA5);
        div_sel = 1'b0;

        // 8-bit bus
        wide_sel = 1'b0;
        issue(0, 1, 0, 16'hBEEF);
        db_in = 16'hCAFE;
        issue(0, 0, 1, 16'h0);
        wait_idle();
        chk("R9 narrow capture", rd_data, 16'h00FE);
        wide_sel = 1'b1;

        // minimum width dominates, zero assert ticks
        set_t(0, 4, 0, 3, 0, 4, 4, 5, 20, 2);
        issue(1, 0, 0, 16'h1111);
        measure(n);
        chk("R5 min width length", 16'(n), 16'd20);

        // request while busy is ignored
        issue(1, 0, 0, 16'h2222);
        repeat (3) @(negedge clk);
        dat_req = 1; wr_data = 16'h9999;
        @(negedge clk);
        dat_req = 0;
        wait_idle();
        @(negedge clk);
        chk("R6 ignored while busy", 16'(lcd_dc), 16'd0);

        // priority
        set_t(1, 8, 2, 6, 2, 7, 9, 10, 3, 5);
        issue(0, 1, 1, 16'h4444);
        wait_idle();
        chk("R6 data over read", 16'(lcd_dc), 16'd1);
        issue(1, 1, 1, 16'h5555);
        wait_idle();
        chk("R6 command first", 16'(lcd_dc), 16'd0);

        // sample tick beyond cycle end: no capture
        set_t(1, 8, 2, 6, 2, 7, 9, 10, 3, 30);
        db_in = 16'h7777;
        issue(0, 0, 1, 16'h0);
        wait_idle();
        chk("R9 late sample skipped", rd_data, 16'h00FE);

        // sample tick exactly at the end
        set_t(1, 8, 2, 6, 2, 7, 9, 10, 3, 10);
        db_in = 16'h6161;
        issue(0, 0, 1, 16'h0);
        wait_idle();
        chk("R9 sample at end", rd_data, 16'h6161);

        // held request: back-to-back cycles
        @(negedge clk);
        dat_req = 1; wr_data = 16'h8181;
        repeat (25) @(negedge clk);
        dat_req = 0;
        wait_idle();
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule